// File: doc/BRIEF.md
# Power-Mode Supervisor

This block sets the operating mode of a power and bus-interface companion chip. A host writes a two-bit mode field, and the block moves between four modes. Standby is the power-on mode. In Normal the system runs fully. In Sleep everything is powered down except wake detection. Overtemp is forced by a hot-die comparator. The block drives the enables for the two regulators and the watchdog, a limp-home flag, and an active-low system reset output.

A Sleep request is accepted only when three things are true: no interrupt is pending, no wake event is pending, and at least one wake source is enabled. If any of these fails, the mode does not change and a short reset pulse is issued. Leaving Sleep on an enabled wake event, or leaving Overtemp once the die has cooled, always lands in Standby and issues a reset pulse. The host chooses whether that pulse is short or long. Pulse lengths are counted in cycles of the block clock, scaled by a cycles-per-millisecond parameter.

Top module: `pwr_mode_sup`

## Requirements
- R1: After reset, `mode_o` is 00 (Standby), `v1_en` and `wd_en` are 1, `v2_en` is 0, `rst_n_o` is 1 and `limp_o` is 0.
- R2: In Standby or Normal, a write of 10 moves to Normal (`mode_o`=10) and a write of 00 moves to Standby (`mode_o`=00), both on the next cycle. A write of 11 is ignored.
- R3: In Standby or Normal, a write of 01 moves to Sleep (`mode_o`=01) on the next cycle when all three of the following hold: `irq_pending` is 0, `wake_pending` is 0, and at least one bit of `wake_en` is 1.
- R4: A write of 01 that fails any Sleep condition leaves the mode unchanged and drives `rst_n_o` low for exactly SHORT_MS*CYC_PER_MS cycles, whatever the value of `long_rst_sel`.
- R5: In Sleep, `v1_en`, `v2_en` and `wd_en` are 0 and `rst_n_o` is 0.
- R6: In Sleep, a `wake_evt` bit whose `wake_en` bit is set moves the block to Standby with `mode_o`=00 and `v1_en`=1. `rst_n_o` then stays low for LONG_MS*CYC_PER_MS cycles if `long_rst_sel`=1, or for SHORT_MS*CYC_PER_MS cycles otherwise. Events on disabled sources are ignored.
- R7: `otp_hot` in Standby or Normal enters Overtemp (`mode_o`=11). In Overtemp, `v1_en`, `v2_en` and `wd_en` are 0, `rst_n_o` is 0 and `limp_o` is 1. `limp_o` stays 1 until reset.
- R8: Overtemp is held while `otp_cool` is 0. With `otp_cool`=1 the block moves to Standby and issues a reset pulse whose length is chosen by `long_rst_sel`, as in R6.
- R9: `otp_hot` takes priority over a mode write in the same cycle.
- R10: In Sleep and in Overtemp, mode writes have no effect. `otp_hot` has no effect in Sleep.
- R11: `v2_en` is 1 in Normal. In Standby it is 1 only when V2_IN_STBY=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the time base for reset pulses |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | One-cycle strobe of a mode-field write |
| mode_wdata | input | 2 | Written mode: 00 Standby, 01 Sleep, 10 Normal, 11 ignored |
| irq_pending | input | 1 | An interrupt is waiting to be serviced |
| wake_pending | input | 1 | A wake event is waiting to be serviced |
| wake_en | input | WAKE_SRCS | Per-source wake enable |
| wake_evt | input | WAKE_SRCS | Per-source wake event |
| otp_hot | input | 1 | Die temperature above the activation threshold |
| otp_cool | input | 1 | Die temperature below the release threshold |
| long_rst_sel | input | 1 | 1 selects the long pulse after a wake or cool-down |
| mode_o | output | 2 | Current mode: 00 Standby, 01 Sleep, 10 Normal, 11 Overtemp |
| v1_en | output | 1 | First regulator enable |
| v2_en | output | 1 | Second regulator enable |
| wd_en | output | 1 | Watchdog enable |
| rst_n_o | output | 1 | Active-low system reset output |
| limp_o | output | 1 | Limp-home flag |

## Verification
The Sleep request is tried four ways: with all conditions met, and with each of the three conditions broken in turn. This separates an accepted entry from a short-reset refusal, and it shows that a long-pulse select does not stretch a refusal. Wake events are driven on enabled and on disabled sources, with short and long selects, which separates a real exit from an ignored event and checks both pulse lengths. The over-temperature input is raised together with a mode write and while in Sleep. The bench then holds Overtemp with the cool flag low before releasing it, which exposes priority errors and premature exits.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   typedef enum logic [1:0] {
      MODE_STBY  = 2'b00,
      MODE_SLEEP = 2'b01,
      MODE_NORM  = 2'b10,
      MODE_OVT   = 2'b11
   } pmode_e;
endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
#(
   parameter int WAKE_SRCS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_wr,
   input  logic [1:0]           mode_wdata,
   input  logic                 irq_pending,
   input  logic                 wake_pending,
   input  logic [WAKE_SRCS-1:0] wake_en,
   input  logic [WAKE_SRCS-1:0] wake_evt,
   input  logic                 otp_hot,
   input  logic                 otp_cool,
   output pmode_e               state,
   output logic                 limp,
   output logic                 pulse_start,
   output logic                 pulse_short
);
   pmode_e state_nx;
   logic   limp_nx;
   logic   sleep_ok;
   logic   woken;

   assign sleep_ok = !irq_pending && !wake_pending && (|wake_en);
   assign woken    = |(wake_evt & wake_en);

   always_comb begin
      state_nx    = state;
      limp_nx     = limp;
      pulse_start = 1'b0;
      pulse_short = 1'b0;
      unique case (state)
         MODE_STBY, MODE_NORM: begin
            if (otp_hot) begin
               state_nx = MODE_OVT;
               limp_nx  = 1'b1;
            end else if (mode_wr) begin
               unique case (mode_wdata)
                  2'b00: state_nx = MODE_STBY;
                  2'b10: state_nx = MODE_NORM;
                  2'b01: begin
                     if (sleep_ok) begin
                        state_nx = MODE_SLEEP;
                     end else begin
                        pulse_start = 1'b1;
                        pulse_short = 1'b1;
                     end
                  end
                  default: state_nx = state;
               endcase
            end
         end
         MODE_SLEEP: begin
            if (woken) begin
               state_nx    = MODE_STBY;
               pulse_start = 1'b1;
            end
         end
         MODE_OVT: begin
            if (otp_cool) begin
               state_nx    = MODE_STBY;
               pulse_start = 1'b1;
            end
         end
         default: state_nx = MODE_STBY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= MODE_STBY;
         limp  <= 1'b0;
      end else begin
         state <= state_nx;
         limp  <= limp_nx;
      end
   end
endmodule

// File: rtl/pwr_rst_pulse.sv
module pwr_rst_pulse #(
   parameter int CYC_PER_MS = 1000,
   parameter int SHORT_MS   = 4,
   parameter int LONG_MS    = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic force_short,
   input  logic long_sel,
   output logic busy
);
   localparam int SHORT_CYC = CYC_PER_MS * SHORT_MS;
   localparam int LONG_CYC  = CYC_PER_MS * LONG_MS;
   localparam int CNT_W     = $clog2(LONG_CYC + 1);
   localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(SHORT_CYC);
   localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(LONG_CYC);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= (long_sel && !force_short) ? LONG_LEN : SHORT_LEN;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
   import pwr_mode_pkg::*;
#(
   parameter bit V2_IN_STBY = 1'b0
) (
   input  pmode_e state,
   output logic   v1_en,
   output logic   v2_en,
   output logic   wd_en,
   output logic   hold_rst
);
   logic awake;

   assign awake    = (state == MODE_STBY) || (state == MODE_NORM);
   assign v1_en    = awake;
   assign wd_en    = awake;
   assign hold_rst = !awake;

   generate
      if (V2_IN_STBY) begin : g_v2_wide
         assign v2_en = awake;
      end else begin : g_v2_norm
         assign v2_en = (state == MODE_NORM);
      end
   endgenerate
endmodule

// File: rtl/pwr_mode_sup.sv
module pwr_mode_sup
   import pwr_mode_pkg::*;
#(
   parameter int WAKE_SRCS  = 3,
   parameter int CYC_PER_MS = 1000,
   parameter int SHORT_MS   = 4,
   parameter int LONG_MS    = 40,
   parameter bit V2_IN_STBY = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_wr,
   input  logic [1:0]           mode_wdata,
   input  logic                 irq_pending,
   input  logic                 wake_pending,
   input  logic [WAKE_SRCS-1:0] wake_en,
   input  logic [WAKE_SRCS-1:0] wake_evt,
   input  logic                 otp_hot,
   input  logic                 otp_cool,
   input  logic                 long_rst_sel,
   output logic [1:0]           mode_o,
   output logic                 v1_en,
   output logic                 v2_en,
   output logic                 wd_en,
   output logic                 rst_n_o,
   output logic                 limp_o
);
   generate
      if (WAKE_SRCS < 1) begin : g_bad_wake
         $error("WAKE_SRCS must be at least 1");
      end
      if (CYC_PER_MS < 1 || SHORT_MS < 1) begin : g_bad_time
         $error("CYC_PER_MS and SHORT_MS must be positive");
      end
      if (LONG_MS < SHORT_MS) begin : g_bad_long
         $error("LONG_MS must not be below SHORT_MS");
      end
   endgenerate

   pmode_e state;
   logic   pulse_start;
   logic   pulse_short;
   logic   pulse_busy;
   logic   hold_rst;

   pwr_mode_fsm #(.WAKE_SRCS(WAKE_SRCS)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_wr      (mode_wr),
      .mode_wdata   (mode_wdata),
      .irq_pending  (irq_pending),
      .wake_pending (wake_pending),
      .wake_en      (wake_en),
      .wake_evt     (wake_evt),
      .otp_hot      (otp_hot),
      .otp_cool     (otp_cool),
      .state        (state),
      .limp         (limp_o),
      .pulse_start  (pulse_start),
      .pulse_short  (pulse_short)
   );

   pwr_rst_pulse #(
      .CYC_PER_MS (CYC_PER_MS),
      .SHORT_MS   (SHORT_MS),
      .LONG_MS    (LONG_MS)
   ) u_pulse (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (pulse_start),
      .force_short (pulse_short),
      .long_sel    (long_rst_sel),
      .busy        (pulse_busy)
   );

   pwr_out_decode #(.V2_IN_STBY(V2_IN_STBY)) u_dec (
      .state    (state),
      .v1_en    (v1_en),
      .v2_en    (v2_en),
      .wd_en    (wd_en),
      .hold_rst (hold_rst)
   );

   assign mode_o  = state;
   assign rst_n_o = !(pulse_busy || hold_rst);
endmodule

// File: rtl/pwr_mode_sup_chk.sv
module pwr_mode_sup_chk #(
   parameter int WAKE_SRCS = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 mode_wr,
   input logic [1:0]           mode_wdata,
   input logic                 irq_pending,
   input logic                 wake_pending,
   input logic [WAKE_SRCS-1:0] wake_en,
   input logic                 otp_hot,
   input logic                 otp_cool,
   input logic [1:0]           mode_o,
   input logic                 v1_en,
   input logic                 v2_en,
   input logic                 wd_en,
   input logic                 rst_n_o,
   input logic                 limp_o
);
   logic awake;
   assign awake = (mode_o == 2'b00) || (mode_o == 2'b10);

   // R5
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b01) |-> (!v1_en && !v2_en && !wd_en && !rst_n_o));

   // R7
   ovt_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b11) |-> (limp_o && !rst_n_o && !v1_en && !v2_en && !wd_en));

   // R7
   limp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      limp_o |=> limp_o);

   // R6
   sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b01) |=> (mode_o == 2'b01 || mode_o == 2'b00));

   // R8
   ovt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b11 && !otp_cool) |=> (mode_o == 2'b11));

   // R8
   ovt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b11 && otp_cool) |=> (mode_o == 2'b00 && !rst_n_o));

   // R9
   otp_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (awake && otp_hot) |=> (mode_o == 2'b11));

   // R4
   sleep_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (awake && !otp_hot && mode_wr && mode_wdata == 2'b01 &&
       (irq_pending || wake_pending || wake_en == '0))
      |=> (mode_o == $past(mode_o) && !rst_n_o));

   // R3
   sleep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (awake && !otp_hot && mode_wr && mode_wdata == 2'b01 &&
       !irq_pending && !wake_pending && wake_en != '0)
      |=> (mode_o == 2'b01));
endmodule

bind pwr_mode_sup pwr_mode_sup_chk #(.WAKE_SRCS(WAKE_SRCS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_wr      (mode_wr),
   .mode_wdata   (mode_wdata),
   .irq_pending  (irq_pending),
   .wake_pending (wake_pending),
   .wake_en      (wake_en),
   .otp_hot      (otp_hot),
   .otp_cool     (otp_cool),
   .mode_o       (mode_o),
   .v1_en        (v1_en),
   .v2_en        (v2_en),
   .wd_en        (wd_en),
   .rst_n_o      (rst_n_o),
   .limp_o       (limp_o)
);

// File: tb/pwr_mode_sup_test.sv
`timescale 1ns/1ps
module pwr_mode_sup_test;
   localparam int CPM   = 5;
   localparam int S_MS  = 4;
   localparam int L_MS  = 10;
   localparam int S_CYC = CPM * S_MS;
   localparam int L_CYC = CPM * L_MS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_wr = 1'b0;
   logic [1:0] mode_wdata = 2'b00;
   logic       irq_pending = 1'b0;
   logic       wake_pending = 1'b0;
   logic [2:0] wake_en = 3'b000;
   logic [2:0] wake_evt = 3'b000;
   logic       otp_hot = 1'b0;
   logic       otp_cool = 1'b0;
   logic       long_rst_sel = 1'b0;
   logic [1:0] mode_o;
   logic       v1_en, v2_en, wd_en, rst_n_o, limp_o;

   int    checks = 0;
   int    failures = 0;
   string phase = "R1";

   pwr_mode_sup #(
      .WAKE_SRCS(3), .CYC_PER_MS(CPM), .SHORT_MS(S_MS), .LONG_MS(L_MS), .V2_IN_STBY(1'b0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .irq_pending(irq_pending), .wake_pending(wake_pending), .wake_en(wake_en),
      .wake_evt(wake_evt), .otp_hot(otp_hot), .otp_cool(otp_cool),
      .long_rst_sel(long_rst_sel), .mode_o(mode_o), .v1_en(v1_en), .v2_en(v2_en),
      .wd_en(wd_en), .rst_n_o(rst_n_o), .limp_o(limp_o)
   );

   always #10 clk = ~clk;

   // behavioural reference: mode 0 stby, 1 sleep, 2 normal, 3 overtemp
   int m_mode = 0;
   int m_cnt  = 0;
   bit m_limp = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_cnt = 0; m_limp = 0;
      end else begin
         int len;
         len = -1;
         if (m_mode == 0 || m_mode == 2) begin
            if (otp_hot) begin
               m_mode = 3; m_limp = 1;
            end else if (mode_wr) begin
               if (mode_wdata == 2'b00) m_mode = 0;
               else if (mode_wdata == 2'b10) m_mode = 2;
               else if (mode_wdata == 2'b01) begin
                  if (!irq_pending && !wake_pending && wake_en != 0) m_mode = 1;
                  else len = S_CYC;
               end
            end
         end else if (m_mode == 1) begin
            if ((wake_evt & wake_en) != 0) begin
               m_mode = 0; len = long_rst_sel ? L_CYC : S_CYC;
            end
         end else begin
            if (otp_cool) begin
               m_mode = 0; len = long_rst_sel ? L_CYC : S_CYC;
            end
         end
         if (len >= 0) m_cnt = len;
         else if (m_cnt > 0) m_cnt = m_cnt - 1;
      end
   end

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference, away from the edge
   always begin
      @(posedge clk);
      #5;
      if (rst_n) begin
         bit e_awake;
         e_awake = (m_mode == 0 || m_mode == 2);
         chk({phase, " mode"}, mode_o, m_mode);
         chk({phase, " v1"}, v1_en, e_awake);
         chk({phase, " v2 R11"}, v2_en, m_mode == 2);
         chk({phase, " wd"}, wd_en, e_awake);
         chk({phase, " rst"}, rst_n_o, !(m_cnt > 0 || !e_awake));
         chk({phase, " limp"}, limp_o, m_limp);
      end
   end

   task automatic write_mode(input logic [1:0] d);
      @(negedge clk);
      mode_wr = 1'b1; mode_wdata = d;
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   task automatic low_len(output int n);
      n = 0;
      while (!rst_n_o && n < 500) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int n;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      phase = "R1";
      chk("R1 mode", mode_o, 0);
      chk("R1 rst", rst_n_o, 1);
      chk("R1 v2", v2_en, 0);

      phase = "R2";
      write_mode(2'b10);
      chk("R2 normal", mode_o, 2);
      chk("R11 v2 normal", v2_en, 1);
      write_mode(2'b11);
      chk("R2 ignore 11", mode_o, 2);
      write_mode(2'b00);
      chk("R2 standby", mode_o, 0);
      write_mode(2'b10);

      phase = "R4";
      wake_en = 3'b001;
      irq_pending = 1'b1;
      write_mode(2'b01);
      chk("R4 irq mode", mode_o, 2);
      low_len(n);
      chk("R4 irq pulse", n, S_CYC);
      irq_pending = 1'b0;
      wake_pending = 1'b1;
      write_mode(2'b01);
      low_len(n);
      chk("R4 wake pending pulse", n, S_CYC);
      wake_pending = 1'b0;
      wake_en = 3'b000;
      long_rst_sel = 1'b1;
      write_mode(2'b01);
      chk("R4 no source mode", mode_o, 2);
      low_len(n);
      chk("R4 no source short", n, S_CYC);

      phase = "R3";
      wake_en = 3'b001;
      write_mode(2'b01);
      chk("R3 sleep", mode_o, 1);
      chk("R5 sleep rst", rst_n_o, 0);
      phase = "R10";
      write_mode(2'b10);
      chk("R10 write in sleep", mode_o, 1);
      @(negedge clk); otp_hot = 1'b1;
      @(negedge clk); otp_hot = 1'b0;
      chk("R10 hot in sleep", mode_o, 1);
      phase = "R6";
      wake_evt = 3'b010;
      @(negedge clk); wake_evt = 3'b000;
      chk("R6 disabled source", mode_o, 1);
      wake_evt = 3'b001;
      @(negedge clk); wake_evt = 3'b000;
      chk("R6 wake mode", mode_o, 0);
      chk("R6 wake v1", v1_en, 1);
      low_len(n);
      chk("R6 long pulse", n, L_CYC);

      long_rst_sel = 1'b0;
      wake_en = 3'b100;
      write_mode(2'b01);
      chk("R3 sleep from standby", mode_o, 1);
      wake_evt = 3'b100;
      @(negedge clk); wake_evt = 3'b000;
      low_len(n);
      chk("R6 short pulse", n, S_CYC);

      phase = "R9";
      @(negedge clk);
      otp_hot = 1'b1; mode_wr = 1'b1; mode_wdata = 2'b10;
      @(negedge clk);
      mode_wr = 1'b0; otp_hot = 1'b0;
      chk("R9 hot wins", mode_o, 3);
      chk("R7 limp", limp_o, 1);
      phase = "R8";
      idle(5);
      write_mode(2'b00);
      chk("R8 held", mode_o, 3);
      long_rst_sel = 1'b1;
      otp_cool = 1'b1;
      @(negedge clk); otp_cool = 1'b0;
      chk("R8 exit", mode_o, 0);
      low_len(n);
      chk("R8 long pulse", n, L_CYC);
      chk("R7 limp sticky", limp_o, 1);

      phase = "R7";
      write_mode(2'b10);
      otp_hot = 1'b1;
      @(negedge clk); otp_hot = 1'b0;
      chk("R7 from normal", mode_o, 3);
      long_rst_sel = 1'b0;
      otp_cool = 1'b1;
      @(negedge clk); otp_cool = 1'b0;
      low_len(n);
      chk("R8 short pulse", n, S_CYC);

      phase = "R1";
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(2);
      chk("R1 limp cleared", limp_o, 0);
      chk("R1 mode again", mode_o, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule